// File: doc/BRIEF.md
# Card Clock Phase Control Register

This block is the clock-timing control register of a storage-card host interface. It holds three 3-bit timing fields: the phase at which receive data is sampled, the phase at which transmit data is driven, and the divider for the card clock. The register also holds a sticky wake-up status flag and the enable for the interrupt that the flag raises. Software reaches the register through a plain write and read port. All other logic reads the fields straight from dedicated output pins.

A timing-mode input selects the preset that the timing fields take. When the mode code changes, the register loads the double-rate preset if the new code is the double-rate code. For every other code it loads the single-rate preset. Besides the raw fields, the block gives two derived outputs. The first is a flag telling the command path to route commands and data through its hold stage, which is needed whenever the drive phase is shifted. The second is the division ratio that the divider field stands for. All ports are plain control and status pins. None of them carries a data stream, so there is no back-pressure.

Top module: `ccpc_top`

## Requirements
- R1: After reset with timing mode 0, the timing fields hold the single-rate preset, and the wake flag and the interrupt enable are 0. Reading the register address returns exactly these values, with all unused bits 0.
- R2: A write with `bus_addr` equal to the register address updates the sample phase from bits [2:0], the drive phase from bits [18:16], the divider from bits [26:24] and the interrupt enable from bit 12. From the next cycle the fields drive their outputs. A read then returns them at the same positions, the wake flag at bit 11, and 0 in every other bit.
- R3: A write to any other address changes nothing, and a read of any other address returns 0.
- R4: `wake_evt` high sets the wake flag (bit 11) at the next clock edge. A register write with bit 11 at 1 clears the flag, and a write with bit 11 at 0 leaves it unchanged.
- R5: When a wake event and a clearing write fall in the same cycle, the flag is 1 afterwards.
- R6: `wake_irq` is high exactly when both the wake flag and the interrupt enable are 1.
- R7: `use_hold` is high exactly when the drive phase field is nonzero.
- R8: When `timing_mode` differs from the mode last applied, the next edge loads all three timing fields from a preset. The double-rate preset is used for code 2 (`DDR_MODE`) and the single-rate preset for every other code. The wake flag and the interrupt enable are left untouched. A mode that stays the same loads nothing.
- R9: When a preset load and a register write fall in the same cycle, the preset wins for the three timing fields. The write's interrupt enable bit and its clear bit still take effect.
- R10: `div_ratio` equals the divider field plus one, which is the factor by which the card clock divides its input clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | ADDR_W | Word address for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| timing_mode | input | MODE_W | Current bus timing mode code |
| wake_evt | input | 1 | Wake-up event, sets the sticky flag |
| sample_phase | output | 3 | Receive sample phase field |
| drive_phase | output | 3 | Transmit drive phase field |
| clk_div | output | 3 | Card clock divider field |
| div_ratio | output | 4 | Divider field plus one |
| use_hold | output | 1 | Command and data must use the hold stage |
| wake_irq | output | 1 | Wake-up interrupt request |

## Verification
A corrupted timing field shows up at its output pin, in `use_hold` or `div_ratio`, and in the read value. It appears one clock after the write or mode change that set it. A wrong flag state, such as a lost set, a missed clear or the wrong winner when a set and a clear collide, appears at `wake_irq` and in read bit 11 one edge after the cycle in question. A stale applied-mode record shows up as a missing or extra preset reload in the cycle after the mode changes. Reads are combinational, so every state error reaches the ports without added delay.

// File: rtl/ccpc_pkg.sv
package ccpc_pkg;
  localparam int FLD_W    = 3;
  localparam int DATA_W   = 32;
  localparam int SMP_LSB  = 0;
  localparam int DRV_LSB  = 16;
  localparam int DIV_LSB  = 24;
  localparam int WAKE_BIT = 11;
  localparam int IEN_BIT  = 12;

  typedef struct packed {
    logic [FLD_W-1:0] smp;
    logic [FLD_W-1:0] drv;
    logic [FLD_W-1:0] div;
  } phase_set_t;
endpackage

// File: rtl/ccpc_preset_sel.sv
module ccpc_preset_sel
  import ccpc_pkg::*;
#(
  parameter int         MODE_W     = 2,
  parameter logic [1:0] DDR_MODE   = 2'd2,
  parameter phase_set_t SDR_PRESET = phase_set_t'({3'd2, 3'd0, 3'd1}),
  parameter phase_set_t DDR_PRESET = phase_set_t'({3'd5, 3'd3, 3'd3})
) (
  input  logic [MODE_W-1:0] mode,
  output phase_set_t        preset
);
  always_comb begin
    if (mode == MODE_W'(DDR_MODE)) preset = DDR_PRESET;
    else                           preset = SDR_PRESET;
  end
endmodule

// File: rtl/ccpc_phase_regs.sv
module ccpc_phase_regs
  import ccpc_pkg::*;
#(
  parameter int         MODE_W    = 2,
  parameter phase_set_t RST_FIELDS = phase_set_t'({3'd2, 3'd0, 3'd1})
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  phase_set_t        preset,
  input  logic              wr_hit,
  input  phase_set_t        wr_fields,
  input  logic              wr_ien,
  output phase_set_t        fields,
  output logic              ien
);
  logic [MODE_W-1:0] applied_mode;
  logic              load;

  assign load = (mode != applied_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields       <= RST_FIELDS;
      applied_mode <= '0;
      ien          <= 1'b0;
    end else begin
      if (load) begin
        fields       <= preset;
        applied_mode <= mode;
      end else if (wr_hit) begin
        fields <= wr_fields;
      end
      if (wr_hit) ien <= wr_ien;
    end
  end

  AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (fields == $past(preset))); // R8

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !wr_hit) |=> $stable(fields)); // R3

  AST_IEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(ien)); // R3
endmodule

// File: rtl/ccpc_wake_flag.sv
module ccpc_wake_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (evt) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  AST_WAKE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag); // R5

  AST_WAKE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !flag); // R4

  AST_WAKE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !evt) |=> $stable(flag)); // R4
endmodule

// File: rtl/ccpc_top.sv
module ccpc_top
  import ccpc_pkg::*;
#(
  parameter int         ADDR_W     = 4,
  parameter logic [3:0] REG_ADDR   = 4'd0,
  parameter int         MODE_W     = 2,
  parameter logic [1:0] DDR_MODE   = 2'd2,
  parameter phase_set_t SDR_PRESET = phase_set_t'({3'd2, 3'd0, 3'd1}),
  parameter phase_set_t DDR_PRESET = phase_set_t'({3'd5, 3'd3, 3'd3})
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [MODE_W-1:0] timing_mode,
  input  logic              wake_evt,
  output logic [2:0]        sample_phase,
  output logic [2:0]        drive_phase,
  output logic [2:0]        clk_div,
  output logic [3:0]        div_ratio,
  output logic              use_hold,
  output logic              wake_irq
);
  localparam int RATIO_W = FLD_W + 1;

  logic       hit;
  logic       wr_hit;
  phase_set_t preset;
  phase_set_t wr_fields;
  phase_set_t fields;
  logic       ien;
  logic       flag;

  assign hit    = (bus_addr == ADDR_W'(REG_ADDR));
  assign wr_hit = bus_wr && hit;

  assign wr_fields.smp = bus_wdata[SMP_LSB +: FLD_W];
  assign wr_fields.drv = bus_wdata[DRV_LSB +: FLD_W];
  assign wr_fields.div = bus_wdata[DIV_LSB +: FLD_W];

  ccpc_preset_sel #(
    .MODE_W(MODE_W), .DDR_MODE(DDR_MODE),
    .SDR_PRESET(SDR_PRESET), .DDR_PRESET(DDR_PRESET)
  ) u_sel (
    .mode(timing_mode), .preset(preset)
  );

  ccpc_phase_regs #(
    .MODE_W(MODE_W), .RST_FIELDS(SDR_PRESET)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .mode(timing_mode), .preset(preset),
    .wr_hit(wr_hit), .wr_fields(wr_fields), .wr_ien(bus_wdata[IEN_BIT]),
    .fields(fields), .ien(ien)
  );

  ccpc_wake_flag u_wake (
    .clk(clk), .rst_n(rst_n), .evt(wake_evt),
    .clr(wr_hit && bus_wdata[WAKE_BIT]), .flag(flag)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      bus_rdata[SMP_LSB +: FLD_W] = fields.smp;
      bus_rdata[DRV_LSB +: FLD_W] = fields.drv;
      bus_rdata[DIV_LSB +: FLD_W] = fields.div;
      bus_rdata[WAKE_BIT]         = flag;
      bus_rdata[IEN_BIT]          = ien;
    end
  end

  assign sample_phase = fields.smp;
  assign drive_phase  = fields.drv;
  assign clk_div      = fields.div;
  assign div_ratio    = RATIO_W'(fields.div) + RATIO_W'(1);
  assign use_hold     = |fields.drv;
  assign wake_irq     = flag && ien;

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_irq && !bus_wr) |=> (wake_irq || wake_evt || $past(wake_evt) || flag)); // R6

  AST_RATIO_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    div_ratio != 4'd0); // R10
endmodule

// File: tb/ccpc_top_test.sv
`timescale 1ns/1ps
module ccpc_top_test;
  import ccpc_pkg::*;

  localparam phase_set_t SDR_P = phase_set_t'({3'd2, 3'd0, 3'd1});
  localparam phase_set_t DDR_P = phase_set_t'({3'd5, 3'd3, 3'd3});

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  timing_mode = '0;
  logic        wake_evt = 1'b0;
  logic [2:0]  sample_phase, drive_phase, clk_div;
  logic [3:0]  div_ratio;
  logic        use_hold, wake_irq;

  int n_chk = 0;
  int n_bad = 0;

  phase_set_t m_f;
  logic       m_en, m_flag;
  logic [1:0] m_mode;

  ccpc_top uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timing_mode(timing_mode),
    .wake_evt(wake_evt), .sample_phase(sample_phase), .drive_phase(drive_phase),
    .clk_div(clk_div), .div_ratio(div_ratio), .use_hold(use_hold),
    .wake_irq(wake_irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    logic [31:0] v = '0;
    if (a == 4'd0) begin
      v[2:0]   = m_f.smp;
      v[18:16] = m_f.drv;
      v[26:24] = m_f.div;
      v[11]    = m_flag;
      v[12]    = m_en;
    end
    return v;
  endfunction

  task automatic check_all(input string tag);
    chk(tag, bus_rdata, exp_read(bus_addr));
    chk(tag, {29'd0, sample_phase}, {29'd0, m_f.smp});
    chk(tag, {29'd0, drive_phase}, {29'd0, m_f.drv});
    chk(tag, {29'd0, clk_div}, {29'd0, m_f.div});
    chk("R10", {28'd0, div_ratio}, {28'd0, 4'(m_f.div) + 4'd1});
    chk("R7", {31'd0, use_hold}, {31'd0, m_f.drv != 3'd0});
    chk("R6", {31'd0, wake_irq}, {31'd0, m_flag && m_en});
  endtask

  // Drive one cycle of stimulus at a falling edge, predict, check at the next falling edge.
  task automatic step(input logic wr, input logic [3:0] a, input logic [31:0] d,
                      input logic wk, input logic [1:0] md, input string tag);
    logic hitw;
    logic load;
    bus_wr = wr; bus_addr = a; bus_wdata = d; wake_evt = wk; timing_mode = md;
    hitw = wr && (a == 4'd0);
    load = (md != m_mode);
    if (load) begin
      m_f    = (md == 2'd2) ? DDR_P : SDR_P;
      m_mode = md;
    end else if (hitw) begin
      m_f = phase_set_t'({d[2:0], d[18:16], d[26:24]});
    end
    if (hitw) m_en = d[12];
    if (wk) m_flag = 1'b1;
    else if (hitw && d[11]) m_flag = 1'b0;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    m_f = SDR_P; m_en = 1'b0; m_flag = 1'b0; m_mode = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1");
    @(negedge clk);
    check_all("R1");

    step(1, 4'd0, 32'hFFFF_FFFF, 0, 2'd0, "R2");
    chk("R2", bus_rdata, 32'h0707_1007);
    step(1, 4'd0, 32'h0500_E002, 0, 2'd0, "R2");
    step(1, 4'd5, 32'h0000_0000, 0, 2'd0, "R3");
    chk("R3", bus_rdata, 32'h0);
    step(0, 4'd0, 32'h0, 1, 2'd0, "R4");
    chk("R4", {31'd0, bus_rdata[11]}, 32'd1);
    step(1, 4'd0, 32'h0000_1000, 0, 2'd0, "R4");
    chk("R4", {31'd0, wake_irq}, 32'd1);
    step(1, 4'd0, 32'h0000_1800, 1, 2'd0, "R5");
    chk("R5", {31'd0, bus_rdata[11]}, 32'd1);
    step(1, 4'd0, 32'h0000_1800, 0, 2'd0, "R4");
    chk("R4", {31'd0, bus_rdata[11]}, 32'd0);
    step(0, 4'd0, 32'h0, 1, 2'd0, "R6");
    step(1, 4'd0, 32'h0700_0007, 0, 2'd2, "R9");
    chk("R9", bus_rdata, 32'h0303_0805);
    step(1, 4'd0, 32'h0101_1001, 0, 2'd2, "R8");
    chk("R8", bus_rdata, 32'h0101_1801);
    step(0, 4'd0, 32'h0, 0, 2'd3, "R8");
    chk("R8", bus_rdata, 32'h0100_1802);
    step(1, 4'd0, 32'h0606_0006, 0, 2'd3, "R2");
    step(0, 4'd0, 32'h0, 0, 2'd1, "R8");
    chk("R8", bus_rdata, 32'h0100_0802);

    for (int i = 0; i < 3000; i++) begin
      logic       wr = ($urandom % 2) == 0;
      logic [3:0] a  = (($urandom % 4) != 0) ? 4'd0 : 4'($urandom);
      logic [31:0] d = $urandom;
      logic       wk = ($urandom % 8) == 0;
      logic [1:0] md = (($urandom % 16) == 0) ? 2'($urandom) : timing_mode;
      step(wr, a, d, wk, md, "R2");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule